// File: doc/BRIEF.md
# Strobe-Addressed Byte Loopback Buffer

This block holds a burst of bytes from a host and plays it back later. Four byte-wide host channels drive it. Each channel has a one-cycle strobe. The first two channels deliver the transfer length as a low byte and a high byte. The third channel delivers payload bytes. The fourth channel returns the stored bytes to the host.

One address counter serves both directions. A low-byte strobe resets the counter to zero and parks the low length byte in a staging register. A high-byte strobe combines the incoming high byte with the staged low byte and commits the 16-bit length. Each payload strobe writes its byte at the current address and moves the counter forward by one. Each return strobe also moves the counter forward by one. The counter stops at the committed length. The counter moves only on strobes, so gaps in either stream never skew the addressing.

To replay a burst of the same size, the host only needs to resend the low byte. That resets the counter and keeps the committed length. The RAM read is registered and looks one address ahead, so the byte for the current address is already on the output when the host's return strobe samples it.

Top module: `byte_loopback_buf`

## Requirements
- R1: While reset is held, and in the cycle after it, `dout_byte` reads 0. After reset the committed length is 0, so payload strobes store nothing until a new length is committed.
- R2: A strobe on `len_lo_stb` sets the counter to 0 at the next edge. The committed length does not change.
- R3: A strobe on `len_hi_stb` commits the length {`len_hi_byte`, most recently staged low byte}, with the high byte in bits 15:8. When both length strobes fire in the same cycle, the low byte presented in that cycle is used.
- R4: When the counter is below the committed length, a `din_stb` stores `din_byte` at RAM address (counter mod depth) and increments the counter by one.
- R5: When the counter has reached the committed length, `din_stb` and `dout_stb` leave both the counter and the RAM unchanged.
- R6: While the counter holds N, `dout_byte` shows the byte stored at address N mod depth. A `dout_stb` below the length moves the counter to N+1, and the output then shows the byte for N+1.
- R7: A strobe on `len_lo_stb` alone restarts a pass with the length already committed.
- R8: Idle cycles between strobes do not change the counter or `dout_byte`.
- R9: A `len_lo_stb` takes priority over `din_stb` and `dout_stb` in the same cycle. That cycle's payload byte is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (20.8 ns nominal) |
| rst | input | 1 | Synchronous active-high reset |
| len_lo_stb | input | 1 | Low length byte strobe; resets the counter |
| len_lo_byte | input | 8 | Low byte of the transfer length |
| len_hi_stb | input | 1 | High length byte strobe; commits the length |
| len_hi_byte | input | 8 | High byte of the transfer length |
| din_stb | input | 1 | Payload byte strobe |
| din_byte | input | 8 | Payload byte |
| dout_stb | input | 1 | Return byte strobe; advances the counter |
| dout_byte | output | 8 | Stored byte at the current address |

## Verification
On every cycle, the assertions check how the counter reacts to each strobe: reset to zero on a clear, a step of one below the length, a hold at the length. They also check the length capture on a high-byte strobe, the hold of the output during idle cycles, and the rule that no RAM write happens at the length limit or alongside a clear. The bench scenarios cover what no single-cycle property can show. A byte written in one pass must come back unchanged in a later pass. Strobes beyond the length must leave earlier contents intact. A length above the RAM depth wraps the writes. Reset must leave stored data in place while it zeroes the committed length.

// File: rtl/lb_pkg.sv
package lb_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned LEN_W  = 2 * BYTE_W;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } len_t;

    typedef enum logic [1:0] {
        CTR_HOLD  = 2'd0,
        CTR_CLEAR = 2'd1,
        CTR_STEP  = 2'd2
    } ctr_act_e;

    // Clear wins over any step request; a step only happens below the limit.
    function automatic ctr_act_e pick_action(input logic clear_req,
                                             input logic step_req,
                                             input logic at_limit);
        if (clear_req)                  return CTR_CLEAR;
        if (step_req && !at_limit)      return CTR_STEP;
        return CTR_HOLD;
    endfunction

endpackage

// File: rtl/lb_len_assembler.sv
module lb_len_assembler
    import lb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lo_stb,
    input  logic [BYTE_W-1:0] lo_byte,
    input  logic              hi_stb,
    input  logic [BYTE_W-1:0] hi_byte,
    output len_t              len
);

    logic [BYTE_W-1:0] lo_stage_q;
    logic [BYTE_W-1:0] lo_eff;
    len_t              len_q;

    assign lo_eff = lo_stb ? lo_byte : lo_stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_stage_q <= '0;
            len_q      <= '0;
        end else begin
            if (lo_stb) lo_stage_q <= lo_byte;
            if (hi_stb) len_q      <= '{hi: hi_byte, lo: lo_eff};
        end
    end

    assign len = len_q;

    assert_len_hi_capture_R3: assert property (@(posedge clk) disable iff (rst)
        hi_stb |=> (len.hi == $past(hi_byte)));

    assert_len_lo_same_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        (hi_stb && lo_stb) |=> (len.lo == $past(lo_byte)));

    assert_len_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !hi_stb |=> $stable(len));

endmodule

// File: rtl/lb_addr_counter.sv
module lb_addr_counter
    import lb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ctr_act_e         act,
    input  logic [LEN_W-1:0] limit,
    output logic [LEN_W-1:0] cnt,
    output logic [LEN_W-1:0] cnt_nxt,
    output logic             at_limit
);

    logic [LEN_W-1:0] cnt_q;

    always_comb begin
        unique case (act)
            CTR_CLEAR: cnt_nxt = '0;
            CTR_STEP:  cnt_nxt = cnt_q + LEN_W'(1);
            default:   cnt_nxt = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_nxt;
    end

    assign cnt      = cnt_q;
    assign at_limit = (cnt_q >= limit);

    assert_clear_to_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (act == CTR_CLEAR) |=> (cnt == '0));

    assert_step_by_one_R4: assert property (@(posedge clk) disable iff (rst)
        (act == CTR_STEP) |=> (cnt == $past(cnt) + LEN_W'(1)));

    assert_no_step_at_limit_R5: assert property (@(posedge clk) disable iff (rst)
        (at_limit && act != CTR_CLEAR) |=> $stable(cnt));

endmodule

// File: rtl/lb_byte_ram.sv
module lb_byte_ram #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) rdata_q <= '0;
        else     rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;

    assert_rdata_reset_R1: assert property (@(posedge clk)
        rst |=> (rdata == '0));

endmodule

// File: rtl/byte_loopback_buf.sv
module byte_loopback_buf
    import lb_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              len_lo_stb,
    input  logic [BYTE_W-1:0] len_lo_byte,
    input  logic              len_hi_stb,
    input  logic [BYTE_W-1:0] len_hi_byte,
    input  logic              din_stb,
    input  logic [BYTE_W-1:0] din_byte,
    input  logic              dout_stb,
    output logic [BYTE_W-1:0] dout_byte
);

    len_t             len;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] cnt_nxt;
    logic             at_limit;
    ctr_act_e         act;
    logic             ram_we;
    logic             warm_q;

    lb_len_assembler u_len (
        .clk     (clk),
        .rst     (rst),
        .lo_stb  (len_lo_stb),
        .lo_byte (len_lo_byte),
        .hi_stb  (len_hi_stb),
        .hi_byte (len_hi_byte),
        .len     (len)
    );

    // Strobe steering: low-byte strobe clears, either data strobe steps.
    assign act    = pick_action(len_lo_stb, din_stb | dout_stb, at_limit);
    assign ram_we = din_stb && (act == CTR_STEP);

    lb_addr_counter u_ctr (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .limit    (len),
        .cnt      (cnt),
        .cnt_nxt  (cnt_nxt),
        .at_limit (at_limit)
    );

    // Read port looks one address ahead so the byte is ready when sampled.
    lb_byte_ram #(
        .ADDR_W (ADDR_W),
        .DATA_W (BYTE_W)
    ) u_ram (
        .clk   (clk),
        .rst   (rst),
        .we    (ram_we),
        .waddr (cnt[ADDR_W-1:0]),
        .wdata (din_byte),
        .raddr (cnt_nxt[ADDR_W-1:0]),
        .rdata (dout_byte)
    );

    always_ff @(posedge clk) begin
        warm_q <= !rst;
    end

    assert_no_write_at_limit_R5: assert property (@(posedge clk) disable iff (rst)
        (din_stb && at_limit) |-> !ram_we);

    assert_clear_blocks_write_R9: assert property (@(posedge clk) disable iff (rst)
        len_lo_stb |-> !ram_we);

    assert_idle_holds_output_R8: assert property (@(posedge clk) disable iff (rst)
        (warm_q && !len_lo_stb && !din_stb && !dout_stb) |=> $stable(dout_byte));

endmodule

// File: tb/byte_loopback_buf_tb.sv
module byte_loopback_buf_tb_top;

    localparam time         CLK_PERIOD = 20.8ns;
    localparam int unsigned AW         = 4;
    localparam int unsigned DEPTH      = 1 << AW;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       len_lo_stb = 1'b0, len_hi_stb = 1'b0, din_stb = 1'b0, dout_stb = 1'b0;
    logic [7:0] len_lo_byte = '0, len_hi_byte = '0, din_byte = '0;
    logic [7:0] dout_byte;

    int n_checks = 0;
    int n_fails  = 0;
    logic [7:0] model [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_loopback_buf #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst),
        .len_lo_stb(len_lo_stb), .len_lo_byte(len_lo_byte),
        .len_hi_stb(len_hi_stb), .len_hi_byte(len_hi_byte),
        .din_stb(din_stb), .din_byte(din_byte),
        .dout_stb(dout_stb), .dout_byte(dout_byte)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic send_lo(input logic [7:0] b);
        len_lo_stb = 1'b1; len_lo_byte = b;
        @(negedge clk);
        len_lo_stb = 1'b0;
    endtask

    task automatic send_hi(input logic [7:0] b);
        len_hi_stb = 1'b1; len_hi_byte = b;
        @(negedge clk);
        len_hi_stb = 1'b0;
    endtask

    task automatic set_len(input int unsigned l);
        send_lo(l[7:0]);
        send_hi(l[15:8]);
    endtask

    task automatic push(input logic [7:0] b);
        din_stb = 1'b1; din_byte = b;
        @(negedge clk);
        din_stb = 1'b0;
    endtask

    task automatic pull_check(input logic [7:0] exp, input string req);
        check(dout_byte, exp, req);
        dout_stb = 1'b1;
        @(negedge clk);
        dout_stb = 1'b0;
    endtask

    // Full readback of all entries with length = depth (R4 stored, R5 untouched)
    task automatic dump_all(input string req);
        set_len(DEPTH);
        for (int i = 0; i < DEPTH; i++) pull_check(model[i], req);
    endtask

    initial begin
        idle(1);
        check(dout_byte, 8'h00, "R1 reset output");
        idle(2);
        rst = 1'b0;
        check(dout_byte, 8'h00, "R1 first cycle after reset");

        // Fill every entry with a known pattern
        set_len(DEPTH);
        for (int i = 0; i < DEPTH; i++) begin
            push(8'hA0 + 8'(i));
            model[i] = 8'hA0 + 8'(i);
        end
        dump_all("R4 initial fill");

        // Sweep every length 0..DEPTH, with stalls and overrun strobes
        for (int l = 0; l <= DEPTH; l++) begin
            set_len(l);
            for (int i = 0; i < l + 2; i++) begin
                logic [7:0] v;
                v = 8'(l * 13 + i * 5 + 1);
                idle(i % 4);                          // R8 stalls
                push(v);
                if (i < l) model[i] = v;
            end
            send_lo(8'(l));                           // R7 restart, no reload
            for (int i = 0; i < l; i++) begin
                idle((i + 1) % 3);                    // R8 stalls on readback
                check(dout_byte, model[i], "R8 output held across idle");
                pull_check(model[i], "R6 readback R7");
            end
            pull_check(model[l % DEPTH], "R5 extra return strobe");
            check(dout_byte, model[l % DEPTH], "R5 counter held at length");
            dump_all("R5 overrun writes ignored");
        end

        // Length with nonzero high byte: 256, writes wrap the RAM
        send_lo(8'h00);
        send_hi(8'h01);
        for (int i = 0; i < 20; i++) begin
            push(8'h30 + 8'(i));
            model[i % DEPTH] = 8'h30 + 8'(i);
        end
        dump_all("R3 high byte length");

        // Both length strobes together: low byte of that cycle is used (length 3)
        len_lo_stb = 1'b1; len_lo_byte = 8'd3; len_hi_stb = 1'b1; len_hi_byte = 8'd0;
        @(negedge clk);
        len_lo_stb = 1'b0; len_hi_stb = 1'b0;
        for (int i = 0; i < 5; i++) begin
            push(8'hC0 + 8'(i));
            if (i < 3) model[i] = 8'hC0 + 8'(i);
        end
        dump_all("R3 same-cycle length bytes");

        // Clear and payload strobe together: clear wins, byte not stored
        set_len(DEPTH);
        push(8'h11);
        model[0] = 8'h11;
        len_lo_stb = 1'b1; len_lo_byte = 8'(DEPTH);
        din_stb = 1'b1; din_byte = 8'h55;
        @(negedge clk);
        len_lo_stb = 1'b0; din_stb = 1'b0;
        check(dout_byte, model[0], "R9 clear beats payload, counter at 0");
        dump_all("R9 clear beats payload");

        // Reset in mid-run: output zero, length zero, contents kept
        rst = 1'b1;
        idle(2);
        check(dout_byte, 8'h00, "R1 output in reset");
        rst = 1'b0;
        for (int i = 0; i < 3; i++) push(8'hEE);
        dump_all("R1 zero length after reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule